// File: doc/BRIEF.md
# Programmable Periodic Wakeup Timer

This block is a free-running interval timer that raises a sticky event flag each time a programmed interval runs out. It is meant for periodic wakeup in a low-activity system. Software writes a 16-bit rate value as two bytes and picks a timebase. It then starts the timer and either polls the flag or lets the request output interrupt a processor. The interval is always an even number of timebase ticks, 2 × (rate + 1).

Two timebases are available. One is the bus clock itself, with one tick per cycle. The other is a slow clock enable, a single-cycle pulse already in the bus clock domain. The rate bytes are locked while the timer runs, so the interval cannot change partway through a period. Stopping the timer clears the running count but leaves an unserviced flag in place.

Top module: `wake_tick_timer`

## Requirements
- R1: With the bus clock as timebase and rate value N, the flag is set every 2 × (N + 1) clock cycles. N = 0 gives one event every 2 cycles.
- R2: Control bit 1 selects the timebase: 1 means every bus cycle is a tick, and 0 means only cycles with `slow_tick` high count. The period is 2 × (N + 1) slow ticks in the second case, and `slow_tick` has no effect in the first.
- R3: The register map has four registers, and every read is combinational with unused bits reading 0. Address 0 is control: bit 0 run, bit 1 timebase select, bit 2 interrupt enable. Address 1 is status, with bit 0 as the flag. Address 2 holds rate bits 15:8 and address 3 holds rate bits 7:0.
- R4: A write to address 2 or 3 changes the rate only while run is 0. While run is 1 the write is dropped and the register reads back its old value.
- R5: After reset every register reads 0 and `irq` is 0.
- R6: The write that sets run starts the count from zero. The first event lands one full period after the clock edge that captured that write.
- R7: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it alone. If an expiry and a clearing write fall on the same edge, the flag stays set.
- R9: Clearing run stops the count and resets it to zero but keeps a pending flag. No event occurs while run is 0.
- R10: On expiry the count restarts with no lost tick, so consecutive events are exactly one period apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Single-cycle slow timebase enable, synchronous to clk |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt request: flag and interrupt enable |

## Verification
The bus-clock sweep covers every rate from 0 to 15, plus 127, 128, 255, 256 and 1000. The byte-boundary values show whether the high and low bytes are joined in the right order. Small rates show off-by-one errors in the 2 × (N + 1) rule, and three back-to-back periods per rate show whether the reload loses a tick. The slow-clock runs use pulse spacings of 1, 2, 3 and 5 cycles. Counting the pulses, not the cycles, separates tick gating from cycle counting, and a quiet `slow_tick` shows that no tick leaks through. Directed patterns cover the remaining cases: a run stopped mid-period and then restarted, rate writes while running, and a clearing write timed onto an expiry edge.

// File: rtl/wt_pkg.sv
package wt_pkg;
   // Register addresses; rate bytes follow RATE_BASE, most significant first
   localparam int unsigned CTRL_ADDR = 0;
   localparam int unsigned STAT_ADDR = 1;
   localparam int unsigned RATE_BASE = 2;

   // Control register layout, bit 0 at the bottom
   typedef struct packed {
      logic irq_en;
      logic src_bus;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wt_regs.sv
module wt_regs
   import wt_pkg::*;
#(
   parameter int unsigned RATE_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              expire,
   output ctrl_t             ctrl,
   output logic [RATE_W-1:0] rate,
   output logic              flag,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned NBYTES = RATE_W / DATA_W;

   // elaboration-time configuration checks
   if (RATE_W % DATA_W != 0) begin : g_bad_lane_split
      initial $fatal(1, "RATE_W must be a whole number of data bytes");
   end
   if (CTRL_W > DATA_W) begin : g_bad_ctrl_width
      initial $fatal(1, "control fields do not fit one data word");
   end
   if ((1 << ADDR_W) < (RATE_BASE + NBYTES)) begin : g_bad_addr_width
      initial $fatal(1, "ADDR_W too narrow for the register map");
   end

   logic ctrl_hit;
   logic stat_hit;
   logic [DATA_W-1:0] lane_data [NBYTES];

   assign ctrl_hit = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign stat_hit = bus_we && (bus_addr == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl <= '0;
      else if (ctrl_hit)
         ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   // expiry has priority over a clearing write on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (expire)
         flag <= 1'b1;
      else if (stat_hit && bus_wdata[0])
         flag <= 1'b0;
   end

   // one byte lane per rate slice, lane 0 holding the top byte
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      localparam int unsigned LSB = RATE_W - (i + 1) * DATA_W;
      logic              hit;
      logic [DATA_W-1:0] lane_q;

      assign hit = bus_we && !ctrl.run && (bus_addr == ADDR_W'(RATE_BASE + i));

      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (hit)
            lane_q <= bus_wdata;
      end

      assign rate[LSB +: DATA_W] = lane_q;
      assign lane_data[i]        = lane_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_ADDR))
         bus_rdata = DATA_W'(ctrl);
      if (bus_addr == ADDR_W'(STAT_ADDR))
         bus_rdata = DATA_W'(flag);
      for (int i = 0; i < NBYTES; i++) begin
         if (bus_addr == ADDR_W'(RATE_BASE + i))
            bus_rdata = lane_data[i];
      end
   end
endmodule

// File: rtl/wt_timebase.sv
module wt_timebase (
   input  logic src_bus,
   input  logic slow_tick,
   output logic tick
);
   // bus clock: every cycle counts; otherwise only slow enable pulses
   always_comb begin
      if (src_bus)
         tick = 1'b1;
      else
         tick = slow_tick;
   end
endmodule

// File: rtl/wt_period_cnt.sv
module wt_period_cnt #(
   parameter int unsigned RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic [RATE_W:0]   cnt,
   output logic              expire
);
   localparam int unsigned CNT_W = RATE_W + 1;

   logic [CNT_W-1:0] limit;
   logic             at_end;

   // period of 2*(rate+1) ticks means terminal count 2*rate+1
   assign limit  = {rate, 1'b1};
   assign at_end = (cnt == limit);
   assign expire = run && tick && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (tick) begin
         if (at_end)
            cnt <= '0;
         else
            cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/wake_tick_timer.sv
module wake_tick_timer
   import wt_pkg::*;
#(
   parameter int unsigned RATE_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   ctrl_t             ctrl;
   logic [RATE_W-1:0] rate;
   logic [RATE_W:0]   cnt;
   logic              flag;
   logic              tick;
   logic              expire;

   wt_regs #(
      .RATE_W (RATE_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .expire    (expire),
      .ctrl      (ctrl),
      .rate      (rate),
      .flag      (flag),
      .bus_rdata (bus_rdata)
   );

   wt_timebase u_tb (
      .src_bus   (ctrl.src_bus),
      .slow_tick (slow_tick),
      .tick      (tick)
   );

   wt_period_cnt #(
      .RATE_W (RATE_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl.run),
      .tick   (tick),
      .rate   (rate),
      .cnt    (cnt),
      .expire (expire)
   );

   assign irq = flag && ctrl.irq_en;
endmodule

// File: rtl/wt_checker.sv
module wt_checker
   import wt_pkg::*;
#(
   parameter int unsigned RATE_W = 16,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic [RATE_W-1:0] rate,
   input logic [RATE_W:0]   cnt,
   input logic              flag,
   input logic              irq,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata0
);
   logic clr_req;
   assign clr_req = bus_we && (bus_addr == ADDR_W'(STAT_ADDR)) && wdata0;

   // R4: rate cannot move while the timer runs
   p_rate_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(rate));

   // R1: count never passes the terminal value 2*rate+1
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= {rate, 1'b1});

   // R1: a new event only follows a terminal count while running
   p_flag_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(run) && ($past(cnt) == {rate, 1'b1})));

   // R9: a stopped timer holds its count at zero
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R7: no request without a pending flag
   p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   // R8: the flag only drops on a clearing write
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);
endmodule

bind wake_tick_timer wt_checker #(
   .RATE_W (RATE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (ctrl.run),
   .rate     (rate),
   .cnt      (cnt),
   .flag     (flag),
   .irq      (irq),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .wdata0   (bus_wdata[0])
);

// File: tb/wake_tick_timer_test.sv
module wake_tick_timer_test;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_HI   = 2'd2;
   localparam logic [1:0] A_LO   = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_tick = 1'b0;
   logic [1:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int cyc = 0;
   int tick_div = 0;
   int tk = 0;
   bit count_on = 1'b0;
   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   wake_tick_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq       (irq)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk)
      slow_tick <= (tick_div != 0) && ((cyc % (tick_div == 0 ? 1 : tick_div)) == 0);

   always @(posedge clk)
      if (count_on && slow_tick) tk <= tk + 1;

   task automatic chk(input string req, input string what, input int got, input int exp);
      nvec++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_flag(output int c);
      logic [7:0] d;
      int n;
      n = 0;
      rd(A_STAT, d);
      while (!d[0] && n < 70000) begin
         @(negedge clk);
         n++;
         rd(A_STAT, d);
      end
      c = d[0] ? cyc : -1;
   endtask

   task automatic load_rate(input int r);
      wr(A_CTRL, 8'h00);
      wr(A_STAT, 8'h01);
      wr(A_HI, 8'(r >> 8));
      wr(A_LO, 8'(r & 255));
   endtask

   task automatic run_bus(input int r);
      int p, c0, c1, c2, c3;
      p = 2 * (r + 1);
      tick_div = 2;
      load_rate(r);
      wr(A_CTRL, 8'h07);
      c0 = cyc;
      wait_flag(c1);
      chk("R6 R1", $sformatf("first period rate %0d", r), c1 - c0, p);
      chk("R7", "irq with flag and enable", int'(irq), 1);
      wr(A_STAT, 8'h01);
      wait_flag(c2);
      chk("R10", $sformatf("second period rate %0d", r), c2 - c1, p);
      wr(A_STAT, 8'h01);
      wait_flag(c3);
      chk("R10", $sformatf("third period rate %0d", r), c3 - c2, p);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic run_slow(input int r, input int div);
      int p, c1;
      p = 2 * (r + 1);
      tick_div = div;
      load_rate(r);
      count_on = 1'b0;
      wr(A_CTRL, 8'h05);
      tk = 0;
      count_on = 1'b1;
      wait_flag(c1);
      chk("R2", $sformatf("slow ticks rate %0d div %0d", r, div), tk, p);
      tk = 0;
      wr(A_STAT, 8'h01);
      wait_flag(c1);
      chk("R10 R2", $sformatf("slow ticks second rate %0d div %0d", r, div), tk, p);
      count_on = 1'b0;
      wr(A_CTRL, 8'h00);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] d;
      int c0, c1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R5", $sformatf("reset read addr %0d", a), int'(d), 0);
      end
      chk("R5", "reset irq", int'(irq), 0);

      // R3: readback and unused bits
      wr(A_HI, 8'hA5);
      wr(A_LO, 8'h3C);
      rd(A_HI, d); chk("R3", "rate high readback", int'(d), 'hA5);
      rd(A_LO, d); chk("R3", "rate low readback", int'(d), 'h3C);
      wr(A_CTRL, 8'hF6);
      rd(A_CTRL, d); chk("R3", "control readback masked", int'(d), 'h06);
      rd(A_STAT, d); chk("R3", "status unused bits", int'(d), 0);
      wr(A_CTRL, 8'h00);

      // R1 R6 R10: bus-clock sweep, slow ticks toggling to show they are ignored (R2)
      for (int r = 0; r < 16; r++) run_bus(r);
      run_bus(127);
      run_bus(128);
      run_bus(255);
      run_bus(256);
      run_bus(1000);

      // R2: slow timebase counts pulses only
      for (int r = 0; r < 5; r++) begin
         run_slow(r, 1);
         run_slow(r, 2);
         run_slow(r, 3);
         run_slow(r, 5);
      end

      // R2: no slow pulses means no progress
      tick_div = 0;
      load_rate(0);
      wr(A_CTRL, 8'h05);
      repeat (40) @(negedge clk);
      rd(A_STAT, d); chk("R2", "no slow ticks no event", int'(d[0]), 0);
      wr(A_CTRL, 8'h00);

      // R4: locked rate while running
      load_rate('h1234);
      wr(A_CTRL, 8'h03);
      wr(A_HI, 8'hAB);
      wr(A_LO, 8'hCD);
      rd(A_HI, d); chk("R4", "high locked", int'(d), 'h12);
      rd(A_LO, d); chk("R4", "low locked", int'(d), 'h34);
      wr(A_CTRL, 8'h00);
      wr(A_HI, 8'hAB);
      rd(A_HI, d); chk("R4", "high writable when stopped", int'(d), 'hAB);

      // R9: stop keeps flag, then stop mid-period and restart
      load_rate(3);
      wr(A_CTRL, 8'h07);
      wait_flag(c1);
      wr(A_CTRL, 8'h04);
      rd(A_STAT, d); chk("R9", "flag kept after stop", int'(d[0]), 1);
      chk("R9", "irq kept after stop", int'(irq), 1);
      wr(A_STAT, 8'h01);
      repeat (30) @(negedge clk);
      rd(A_STAT, d); chk("R9", "no event while stopped", int'(d[0]), 0);
      wr(A_CTRL, 8'h07);
      repeat (3) @(negedge clk);
      wr(A_CTRL, 8'h04);
      wr(A_CTRL, 8'h07);
      c0 = cyc;
      wait_flag(c1);
      chk("R9 R6", "restart period from zero", c1 - c0, 8);

      // R7: request gating
      wr(A_CTRL, 8'h00);
      rd(A_STAT, d); chk("R7", "flag still set", int'(d[0]), 1);
      chk("R7", "irq off with enable 0", int'(irq), 0);
      wr(A_CTRL, 8'h04);
      chk("R7", "irq on with enable 1", int'(irq), 1);

      // R8: write 0 ignored, write 1 clears
      wr(A_STAT, 8'hFE);
      rd(A_STAT, d); chk("R8", "write 0 keeps flag", int'(d[0]), 1);
      wr(A_STAT, 8'h01);
      rd(A_STAT, d); chk("R8", "write 1 clears flag", int'(d[0]), 0);
      chk("R8", "irq drops with flag", int'(irq), 0);

      // R8: clear landing on an expiry edge (period 2) keeps the flag
      load_rate(0);
      wr(A_CTRL, 8'h03);
      wait_flag(c1);
      wr(A_STAT, 8'h01);
      rd(A_STAT, d); chk("R8", "set wins over clear", int'(d[0]), 1);
      // period 4: same clear timing lands between expiries
      load_rate(1);
      wr(A_CTRL, 8'h03);
      wait_flag(c1);
      wr(A_STAT, 8'h01);
      rd(A_STAT, d); chk("R8", "clear between expiries", int'(d[0]), 0);
      wr(A_CTRL, 8'h00);

      summary();
   end
endmodule